// File: doc/BRIEF.md
# Shared-Line Interrupt Aggregator

This block gathers a large number of level-sensitive peripheral interrupt sources, organised as 32-bit source words, and concentrates them onto four shared CPU interrupt lines. Every source owns a pending bit in one status array that all lines see. Software retires pending bits through a write-one-to-clear window, one clear word per source word. Each CPU line has a private bank of enable words covering every source word, so any source can be steered to any line, or to several lines, by setting its bit in the matching banks.

A line's request is formed from the pending bits ANDed with that line's enables and ORed across all words, and is gated by a per-line master enable. The master enable sits in bit 0 of the line's first enable word, and that bit also serves as the enable of source 0 in word 0. Each CPU line is a one-cycle pulse produced when its gated request rises. A line that stays requested does not pulse again, so software re-arms it by clearing and then setting the master enable.

A single-cycle register port with word addresses gives access to status (read), clear (write; reads return zero) and enable banks (read/write). Status words come first, then clear words, then the enable banks ordered by line and then by word.

Top module: `irq_share_ctrl`

## Requirements
- R1: After reset all pending bits and all enable words read 0 and no CPU line pulses.
- R2: A source that is high in a cycle sets its pending bit at that clock edge, whether or not any line enables it, and a disabled pending source causes no pulse.
- R3: A write of mask M to the clear word of word w clears exactly the pending bits of word w that are 1 in M. All other pending bits, including those in other words, keep their value.
- R4: When a source is high in the same cycle as a clear write covering its bit, the pending bit remains set.
- R5: Enabling a source that is already pending on a line whose master enable is 1 pulses that line in the cycle after the enable write.
- R6: While bit 0 of enable word 0 of a line is 0, that line never pulses. When it is 1, source 0 of word 0 reaches that line with no further enable.
- R7: A pending source pulses exactly the lines whose enable bank has its bit (same word, same bit position) set, and no other line.
- R8: A CPU line pulse lasts one cycle. A request that stays high produces no further pulse.
- R9: Writing 0 and then 1 to the master enable while an enabled source is still pending produces a new one-cycle pulse in the cycle after the write of 1.
- R10: Word address map for NUM_WORDS=2: status w at address w, clear w at address 2+w, enable of line o word w at address 4+2*o+w. Clear addresses and addresses 12 to 15 read 0. An enable write changes only the addressed word.
- R11: After 0 is written to every enable word of every line, no line pulses while sources keep arriving, and those sources still latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_WORDS*WORD_W | Level source inputs, word w at bits [w*WORD_W +: WORD_W] |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | WORD_W | Register write data |
| reg_rdata_o | output | WORD_W | Register read data, combinational from address |
| irq_o | output | NUM_OUT | One-cycle interrupt pulse per CPU line |

## Verification
A corrupted pending bit shows within one read of the status word, and through a spurious or missing pulse in the first cycle after the related enable becomes active. A stuck edge register shows up as a pulse repeated while the request is held, or as no pulse after a master enable toggle, in the cycle that follows the write. Routing errors between banks appear as a pulse on the wrong line in the same cycle that the correct line should fire, so the bench compares all four lines together after every source event.

// File: rtl/irq_share_pkg.sv
package irq_share_pkg;

  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_STATUS = 2'd1,
    K_CLEAR  = 2'd2,
    K_ENABLE = 2'd3
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] out_idx;
    logic [7:0] word_idx;
  } reg_dec_t;

  // status: [0,nw), clear: [nw,2nw), enables: line-major then word
  function automatic reg_dec_t dec_addr(input int unsigned a,
                                        input int unsigned nw,
                                        input int unsigned no);
    reg_dec_t d;
    int unsigned rel;
    d.kind     = K_NONE;
    d.out_idx  = '0;
    d.word_idx = '0;
    rel        = 0;
    if (a < nw) begin
      d.kind     = K_STATUS;
      d.word_idx = 8'(a);
    end else if (a < 2 * nw) begin
      d.kind     = K_CLEAR;
      d.word_idx = 8'(a - nw);
    end else if (a < 2 * nw + no * nw) begin
      rel        = a - 2 * nw;
      d.kind     = K_ENABLE;
      d.out_idx  = 8'(rel / nw);
      d.word_idx = 8'(rel % nw);
    end
    return d;
  endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned NUM_WORDS = 2,
  parameter int unsigned WORD_W    = 32,
  localparam int unsigned TOT_W    = NUM_WORDS * WORD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TOT_W-1:0] src_i,
  input  logic [TOT_W-1:0] clr_i,
  output logic [TOT_W-1:0] status_o
);

  logic [TOT_W-1:0] status_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | src_i;
  end

  assign status_o = status_q;

endmodule

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
  parameter int unsigned NUM_WORDS = 2,
  parameter int unsigned WORD_W    = 32,
  localparam int unsigned TOT_W    = NUM_WORDS * WORD_W,
  localparam int unsigned WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WIDX_W-1:0] word_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [TOT_W-1:0]  en_o
);

  logic [TOT_W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (we_i) begin
      for (int w = 0; w < int'(NUM_WORDS); w++) begin
        if (int'(word_i) == w) en_q[w*WORD_W +: WORD_W] <= wdata_i;
      end
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/irq_edge_out.sv
module irq_edge_out #(
  parameter int unsigned TOT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TOT_W-1:0] status_i,
  input  logic [TOT_W-1:0] en_i,
  output logic             irq_o
);

  logic req;
  logic req_q;

  // en_i[0] doubles as the line's master enable
  assign req = en_i[0] & (|(status_i & en_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req;
  end

  assign irq_o = req & ~req_q;

endmodule

// File: rtl/irq_share_ctrl.sv
module irq_share_ctrl
  import irq_share_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 2,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_OUT   = 4,
  localparam int unsigned TOT_W    = NUM_WORDS * WORD_W,
  localparam int unsigned N_REGS   = 2 * NUM_WORDS + NUM_OUT * NUM_WORDS,
  localparam int unsigned ADDR_W   = (N_REGS > 1) ? $clog2(N_REGS) : 1,
  localparam int unsigned WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TOT_W-1:0]   src_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [WORD_W-1:0]  reg_wdata_i,
  output logic [WORD_W-1:0]  reg_rdata_o,
  output logic [NUM_OUT-1:0] irq_o
);

  reg_dec_t                      dec;
  logic [TOT_W-1:0]              status_q;
  logic [TOT_W-1:0]              clr_mask;
  logic [NUM_OUT-1:0][TOT_W-1:0] en_flat;

  assign dec = dec_addr(int'(reg_addr_i), NUM_WORDS, NUM_OUT);

  for (genvar w = 0; w < int'(NUM_WORDS); w++) begin : g_clr
    assign clr_mask[w*WORD_W +: WORD_W] =
      (reg_we_i && dec.kind == K_CLEAR && dec.word_idx == 8'(w)) ? reg_wdata_i : '0;
  end

  irq_pend_bank #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W)
  ) i_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .clr_i    (clr_mask),
    .status_o (status_q)
  );

  for (genvar o = 0; o < int'(NUM_OUT); o++) begin : g_out
    logic bank_we;
    assign bank_we = reg_we_i && dec.kind == K_ENABLE && dec.out_idx == 8'(o);

    irq_en_bank #(
      .NUM_WORDS (NUM_WORDS),
      .WORD_W    (WORD_W)
    ) i_en (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bank_we),
      .word_i  (dec.word_idx[WIDX_W-1:0]),
      .wdata_i (reg_wdata_i),
      .en_o    (en_flat[o])
    );

    irq_edge_out #(
      .TOT_W (TOT_W)
    ) i_edge (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .status_i (status_q),
      .en_i     (en_flat[o]),
      .irq_o    (irq_o[o])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int w = 0; w < int'(NUM_WORDS); w++) begin
      if (dec.word_idx == 8'(w)) begin
        if (dec.kind == K_STATUS) reg_rdata_o = status_q[w*WORD_W +: WORD_W];
        for (int o = 0; o < int'(NUM_OUT); o++) begin
          if (dec.kind == K_ENABLE && dec.out_idx == 8'(o))
            reg_rdata_o = en_flat[o][w*WORD_W +: WORD_W];
        end
      end
    end
  end

endmodule

// File: rtl/irq_share_chk.sv
module irq_share_chk #(
  parameter int unsigned NUM_WORDS = 2,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_OUT   = 4,
  localparam int unsigned TOT_W    = NUM_WORDS * WORD_W
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [TOT_W-1:0]          src_i,
  input logic [TOT_W-1:0]          status_i,
  input logic [TOT_W-1:0]          clr_i,
  input logic [NUM_OUT-1:0][TOT_W-1:0] en_i,
  input logic [NUM_OUT-1:0]        irq_i
);

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> ((status_i & $past(src_i)) == $past(src_i)));

  a_r3_clear_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|status_i) |=> ((~status_i & $past(status_i) & ~$past(clr_i)) == '0));

  for (genvar o = 0; o < int'(NUM_OUT); o++) begin : g_line
    a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[o] |=> !irq_i[o]);

    a_r6_master_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[o] |-> en_i[o][0]);

    a_r7_enabled_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[o] |-> (|(status_i & en_i[o])));
  end

endmodule

bind irq_share_ctrl irq_share_chk #(
  .NUM_WORDS (NUM_WORDS),
  .WORD_W    (WORD_W),
  .NUM_OUT   (NUM_OUT)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .src_i    (src_i),
  .status_i (status_q),
  .clr_i    (clr_mask),
  .en_i     (en_flat),
  .irq_i    (irq_o)
);

// File: tb/test_irq_share_ctrl.sv
`timescale 1ns/1ps
module test_irq_share_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irq_share_ctrl i_irq_share_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .src_i       (src),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  typedef struct packed {
    logic [1:0]  line;
    logic        src_w;
    logic [4:0]  src_b;
    logic        en_w;
    logic [31:0] en_val;
    logic        master;
    logic [3:0]  exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 5'd5,  1'b0, 32'h0000_0020, 1'b1, 4'b0001},
    '{2'd1, 1'b1, 5'd0,  1'b1, 32'h0000_0001, 1'b1, 4'b0010},
    '{2'd2, 1'b1, 5'd31, 1'b1, 32'h8000_0000, 1'b1, 4'b0100},
    '{2'd3, 1'b0, 5'd17, 1'b0, 32'h0002_0000, 1'b1, 4'b1000},
    '{2'd3, 1'b0, 5'd17, 1'b0, 32'h0002_0000, 1'b0, 4'b0000},
    '{2'd1, 1'b0, 5'd4,  1'b0, 32'h0000_0008, 1'b1, 4'b0000},
    '{2'd2, 1'b1, 5'd9,  1'b0, 32'h0000_0200, 1'b1, 4'b0000},
    '{2'd0, 1'b0, 5'd0,  1'b0, 32'h0000_0000, 1'b1, 4'b0001}
  };

  function automatic logic [3:0] a_stat(int w);        return 4'(w);           endfunction
  function automatic logic [3:0] a_clr(int w);         return 4'(2 + w);       endfunction
  function automatic logic [3:0] a_en(int o, int w);   return 4'(4 + 2*o + w); endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse_src(int w, int b);
    @(negedge clk);
    src[w*32 + b] = 1'b1;
    @(negedge clk);
    src = '0;
  endtask

  task automatic quiesce();
    for (int o = 0; o < 4; o++)
      for (int w = 0; w < 2; w++) wr(a_en(o, w), 32'h0);
    wr(a_clr(0), 32'hFFFF_FFFF);
    wr(a_clr(1), 32'hFFFF_FFFF);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {28'h0, irq}, 32'h0);
    rd(a_stat(0), d); check("R1 status0", d, 32'h0);
    rd(a_stat(1), d); check("R1 status1", d, 32'h0);
    rd(a_en(2, 1), d); check("R1 enable", d, 32'h0);
    rd(a_en(0, 0), d); check("R1 master", d, 32'h0);

    // R7 / R6 table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      quiesce();
      wr(a_en(int'(v.line), 0), (v.en_w == 1'b0 ? v.en_val : 32'h0) | {31'h0, v.master});
      if (v.en_w == 1'b1) wr(a_en(int'(v.line), 1), v.en_val);
      pulse_src(int'(v.src_w), int'(v.src_b));
      check($sformatf("R7 R6 vector %0d irq", i), {28'h0, irq}, {28'h0, v.exp});
    end

    // R2 latch while disabled
    quiesce();
    pulse_src(1, 7);
    check("R2 no pulse", {28'h0, irq}, 32'h0);
    rd(a_stat(1), d); check("R2 latched", d, 32'h0000_0080);

    // R5 late enable
    wr(a_en(0, 0), 32'h1);
    check("R5 master only", {28'h0, irq}, 32'h0);
    wr(a_en(0, 1), 32'h0000_0080);
    check("R5 pulse on enable", {28'h0, irq}, 32'h1);

    // R8 held request
    @(negedge clk);
    check("R8 one cycle", {28'h0, irq}, 32'h0);
    repeat (3) @(negedge clk);
    check("R8 no repeat", {28'h0, irq}, 32'h0);

    // R9 master retrigger
    wr(a_en(0, 0), 32'h0);
    check("R9 master off", {28'h0, irq}, 32'h0);
    wr(a_en(0, 0), 32'h1);
    check("R9 retrigger", {28'h0, irq}, 32'h1);
    @(negedge clk);
    check("R9 single", {28'h0, irq}, 32'h0);

    // R3 exact clear
    pulse_src(0, 4); pulse_src(0, 5); pulse_src(0, 6); pulse_src(0, 7);
    rd(a_stat(0), d); check("R3 before clear", d, 32'h0000_00F0);
    wr(a_clr(0), 32'h0000_0030);
    rd(a_stat(0), d); check("R3 masked clear", d, 32'h0000_00C0);
    rd(a_stat(1), d); check("R3 other word", d, 32'h0000_0080);

    // R4 set beats clear
    @(negedge clk);
    src[6] = 1'b1; we = 1'b1; addr = a_clr(0); wdata = 32'h0000_0040;
    @(negedge clk);
    src = '0; we = 1'b0;
    rd(a_stat(0), d); check("R4 set wins", d, 32'h0000_00C0);

    // R10 address map
    rd(a_clr(0), d); check("R10 clear reads zero", d, 32'h0);
    wr(a_en(3, 1), 32'hA5A5_0000);
    rd(4'd11, d); check("R10 enable 3/1 at 11", d, 32'hA5A5_0000);
    rd(a_en(3, 0), d); check("R10 neighbour word", d, 32'h0);
    rd(a_en(2, 1), d); check("R10 neighbour bank", d, 32'h0);
    rd(4'd12, d); check("R10 unmapped 12", d, 32'h0);
    rd(4'd15, d); check("R10 unmapped 15", d, 32'h0);

    // R11 quiesce
    quiesce();
    for (int o = 0; o < 4; o++) begin
      wr(a_en(o, 0), 32'hFFFF_FFFF);
      wr(a_en(o, 1), 32'hFFFF_FFFF);
    end
    for (int o = 0; o < 4; o++)
      for (int w = 0; w < 2; w++) wr(a_en(o, w), 32'h0);
    pulse_src(1, 3);
    check("R11 quiet a", {28'h0, irq}, 32'h0);
    pulse_src(0, 0);
    check("R11 quiet b", {28'h0, irq}, 32'h0);
    repeat (2) @(negedge clk);
    check("R11 quiet c", {28'h0, irq}, 32'h0);
    rd(a_stat(1), d); check("R11 still latches", d, 32'h0000_0008);
    rd(a_stat(0), d); check("R11 still latches w0", d, 32'h0000_0001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule